// File: doc/BRIEF.md
# Sinusoidal Jitter Bit Transmitter

This block sends a pseudo-random serial bit stream whose transitions are deliberately displaced in time by a single-tone sinusoidal timing error of known size. Its purpose is to close an eye diagram on purpose and by a known amount. The whole block runs from one fast reference clock. A phase accumulator divides that clock down to a bit rate near 1 Mb/s. A second accumulator addresses a sine table. The table sample, scaled by an amplitude setting, is added as a phase offset to the first accumulator before its top bit is taken as the bit clock.

A third accumulator, with the same tuning word but no modulation, provides a clean clock and strobe at the nominal rate. This output is meant to trigger an oscilloscope. Bit launch is a one-cycle enable in the reference domain, not a derived clock. The step sizes and the amplitude are held in shadow registers that only reload when the main accumulator overflows.

Top module: `sjit_tx`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven low, all accumulators clear, and the bit generator returns to its seed 7'h01.
- R2: `trig_clk_o` follows, one register later, the top bit of an unmodulated accumulator that adds the active tuning word each cycle. `trig_stb_o` is high for exactly the one cycle after each low-to-high change of that bit.
- R3: `launch_o` is high for exactly one cycle whenever `bit_clk_o` (the registered top bit of the modulated phase) goes from low to high.
- R4: `ser_o` changes only in the cycle where `launch_o` is high. It then presents bit 6 of a 7-bit shift register, which next becomes {s[5:0], s[6]^s[5]} (polynomial x^7+x^6+1). The register starts from seed 7'h01, so the first launched bit is 0.
- R5: With the active amplitude at zero, `launch_o` equals `trig_stb_o` and `bit_clk_o` equals `trig_clk_o` on every cycle.
- R6: The phase offset is the 12-bit signed sine sample (256 entries per period, peak ±2047) times the 8-bit unsigned amplitude, shifted left by 11. The launch times therefore differ from the clean strobe by up to amplitude·2047·2^11 / tuning-word reference cycles.
- R7: Under slow modulation, each interval between successive launches stays within the nominal period 2^32/tuning-word plus or minus the peak deviation of R6 (plus one cycle of quantisation).
- R8: Averaged over many modulation periods, the launch period equals 2^32 / tuning-word reference cycles.
- R9: The tuning words and the amplitude take effect only in the cycle after the main accumulator overflows. A changed tuning word therefore never yields a bit shorter than the shorter of the old and new nominal periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_i | input | 32 | Bit-rate step added to the main and clean accumulators |
| jit_ftw_i | input | 32 | Step of the sine-table accumulator (sets the jitter tone) |
| amp_i | input | 8 | Jitter amplitude scale |
| ser_o | output | 1 | Jittered serial data |
| bit_clk_o | output | 1 | Modulated bit clock level |
| launch_o | output | 1 | One-cycle enable on each modulated bit edge |
| trig_clk_o | output | 1 | Clean nominal-rate clock level |
| trig_stb_o | output | 1 | One-cycle strobe on each clean clock rising edge |

## Verification
The pulse-shape properties assume the tuning word is below 2^31, so each clock level lasts at least two cycles. They also assume the offset moves by much less than half a bit per bit period, so the modulated top bit never flickers. The stimulus keeps within this by using tuning words of 2^26 and 2^27 and a sine step of 2^20, which gives a tone 64 bits long. The coincidence property only applies after the amplitude has been zero for three cycles. The bench enables its matching coincidence check only after a settling gap of several bit periods.

// File: rtl/sjit_pkg.sv
package sjit_pkg;

  // Integer sine approximation over one period of 2^aw points, peak 2^(dw-1)-1.
  // Each half period uses a rational fit 16p/(5n^2-4p) with p = x(n-x).
  function automatic int sine_q(input int idx, input int aw, input int dw);
    longint n, x, p, pk, v;
    n  = longint'(1) << (aw - 1);
    x  = longint'(idx) % n;
    p  = x * (n - x);
    pk = (longint'(1) << (dw - 1)) - 1;
    v  = (pk * 16 * p) / (5 * n * n - 4 * p);
    if (longint'(idx) >= n) v = -v;
    return int'(v);
  endfunction

endpackage

// File: rtl/sjit_phase_acc.sv
module sjit_phase_acc #(
  parameter int W     = 32,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     step_i,
  output logic [OUT_W-1:0] phase_o
);

  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step_i;
  end

  // Only the upper bits are brought out; callers pick how many they need.
  assign phase_o = acc[W-1 -: OUT_W];

endmodule

// File: rtl/sjit_sine_rom.sv
module sjit_sine_rom import sjit_pkg::*; #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr_i,
  output logic signed [DW-1:0] data_o
);

  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(sine_q(i, AW, DW));
  end

  // Registered read so the table maps onto a block RAM with output register.
  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= mem[addr_i];
  end

endmodule

// File: rtl/sjit_prbs7.sv
module sjit_prbs7 #(
  parameter logic [6:0] SEED = 7'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic bit_o
);

  logic [6:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= SEED;
    else if (adv_i) sr <= {sr[5:0], sr[6] ^ sr[5]};
  end

  assign bit_o = sr[6];

endmodule

// File: rtl/sjit_tx.sv
module sjit_tx import sjit_pkg::*; #(
  parameter int         PHASE_W = 32,
  parameter int         LUT_AW  = 8,
  parameter int         SIN_W   = 12,
  parameter int         AMP_W   = 8,
  parameter logic [6:0] SEED    = 7'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic [PHASE_W-1:0] jit_ftw_i,
  input  logic [AMP_W-1:0]   amp_i,
  output logic               ser_o,
  output logic               bit_clk_o,
  output logic               launch_o,
  output logic               trig_clk_o,
  output logic               trig_stb_o
);

  localparam int PROD_W = SIN_W + AMP_W + 1;
  // Largest product lands just under a quarter of a bit period.
  localparam int OFS_SH = PHASE_W - 2 - (SIN_W - 1) - AMP_W;

  // Shadow copies of the programmable settings
  logic [PHASE_W-1:0] ftw_sh, jftw_sh;
  logic [AMP_W-1:0]   amp_sh;

  logic [PHASE_W-1:0] main_ph;
  logic               main_wrap;
  logic [0:0]         trig_top;
  logic [LUT_AW-1:0]  lut_addr;
  logic signed [SIN_W-1:0]   sine;
  logic signed [PROD_W-1:0]  prod;
  logic signed [PHASE_W-1:0] off_ext, off_q;
  logic               mid_carry, mod_msb;
  logic               launch_nxt, trig_nxt, prbs_bit;

  // Overflow of main_ph + ftw_sh, without building the full sum.
  assign main_wrap = main_ph > ~ftw_sh;

  always_ff @(posedge clk) begin
    if (rst || main_wrap) begin
      ftw_sh  <= ftw_i;
      jftw_sh <= jit_ftw_i;
      amp_sh  <= amp_i;
    end
  end

  sjit_phase_acc #(.W(PHASE_W), .OUT_W(PHASE_W)) u_main (
    .clk(clk), .rst(rst), .step_i(ftw_sh), .phase_o(main_ph)
  );

  sjit_phase_acc #(.W(PHASE_W), .OUT_W(1)) u_clean (
    .clk(clk), .rst(rst), .step_i(ftw_sh), .phase_o(trig_top)
  );

  sjit_phase_acc #(.W(PHASE_W), .OUT_W(LUT_AW)) u_tone (
    .clk(clk), .rst(rst), .step_i(jftw_sh), .phase_o(lut_addr)
  );

  sjit_sine_rom #(.AW(LUT_AW), .DW(SIN_W)) u_rom (
    .clk(clk), .rst(rst), .addr_i(lut_addr), .data_o(sine)
  );

  // Scale the tone sample and place it in the upper phase bits.
  assign prod    = sine * $signed({1'b0, amp_sh});
  assign off_ext = PHASE_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) off_q <= '0;
    else     off_q <= off_ext <<< OFS_SH;
  end

  // Top bit of main_ph + off_q: the two top bits plus the carry out of the rest.
  assign mid_carry = main_ph[PHASE_W-2:0] > ~off_q[PHASE_W-2:0];
  assign mod_msb   = main_ph[PHASE_W-1] ^ off_q[PHASE_W-1] ^ mid_carry;

  assign launch_nxt = mod_msb & ~bit_clk_o;
  assign trig_nxt   = trig_top[0] & ~trig_clk_o;

  sjit_prbs7 #(.SEED(SEED)) u_prbs (
    .clk(clk), .rst(rst), .adv_i(launch_nxt), .bit_o(prbs_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_clk_o  <= 1'b0;
      launch_o   <= 1'b0;
      trig_clk_o <= 1'b0;
      trig_stb_o <= 1'b0;
      ser_o      <= 1'b0;
    end else begin
      bit_clk_o  <= mod_msb;
      launch_o   <= launch_nxt;
      trig_clk_o <= trig_top[0];
      trig_stb_o <= trig_nxt;
      if (launch_nxt) ser_o <= prbs_bit;
    end
  end

endmodule

// File: rtl/sjit_tx_chk.sv
module sjit_tx_chk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ser_o,
  input logic               bit_clk_o,
  input logic               launch_o,
  input logic               trig_clk_o,
  input logic               trig_stb_o,
  input logic               main_wrap,
  input logic [PHASE_W-1:0] ftw_sh,
  input logic [AMP_W-1:0]   amp_sh
);

  // Cycles the active amplitude has been zero, saturating at 3.
  logic [1:0] zero_run;
  always_ff @(posedge clk) begin
    if (rst || amp_sh != '0) zero_run <= 2'd0;
    else if (zero_run != 2'd3) zero_run <= zero_run + 2'd1;
  end

  assert_trig_single_R2: assert property (@(posedge clk) disable iff (rst)
    trig_stb_o |=> !trig_stb_o);

  assert_trig_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    trig_stb_o |-> (trig_clk_o && !$past(trig_clk_o)));

  assert_launch_single_R3: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> !launch_o);

  assert_launch_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> (bit_clk_o && !$past(bit_clk_o)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !launch_o |-> $stable(ser_o));

  assert_zero_amp_align_R5: assert property (@(posedge clk) disable iff (rst)
    (zero_run == 2'd3) |-> (launch_o == trig_stb_o && bit_clk_o == trig_clk_o));

  assert_ftw_on_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(main_wrap) |-> $stable(ftw_sh));

  assert_amp_on_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(main_wrap) |-> $stable(amp_sh));

endmodule

bind sjit_tx sjit_tx_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .ser_o(ser_o), .bit_clk_o(bit_clk_o),
  .launch_o(launch_o), .trig_clk_o(trig_clk_o), .trig_stb_o(trig_stb_o),
  .main_wrap(main_wrap), .ftw_sh(ftw_sh), .amp_sh(amp_sh)
);

// File: tb/test_sjit_tx.sv
`timescale 1ns/1ps
module test_sjit_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ftw  = 32'h0400_0000;   // period 64
  logic [31:0] jftw = 32'h0010_0000;   // tone lasts 4096 cycles
  logic [7:0]  amp  = 8'd0;
  logic ser_o, bit_clk_o, launch_o, trig_clk_o, trig_stb_o;

  always #4 clk = ~clk;

  sjit_tx i_sjit_tx (
    .clk(clk), .rst(rst), .ftw_i(ftw), .jit_ftw_i(jftw), .amp_i(amp),
    .ser_o(ser_o), .bit_clk_o(bit_clk_o), .launch_o(launch_o),
    .trig_clk_o(trig_clk_o), .trig_stb_o(trig_stb_o)
  );

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural model of the clean path and the shadowed step (R2, R9)
  logic [31:0] m_ph, m_fsh;
  logic [32:0] m_sum;
  logic        m_tclk, m_tstb;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_fsh = ftw; m_tclk = 0; m_tstb = 0;
    end else begin
      m_tstb = m_ph[31] & ~m_tclk;
      m_tclk = m_ph[31];
      m_sum  = {1'b0, m_ph} + {1'b0, m_fsh};
      m_ph   = m_sum[31:0];
      if (m_sum[32]) m_fsh = ftw;
    end
  end

  // Flags written only by the stimulus
  bit coinc = 0, r9_en = 0, meas = 0;
  // Observation state written only by the monitor
  logic [6:0] blf;
  logic       exp_ser;
  int r9_prev = -1, m_prev = -1, last_trig = 0;
  int max_err = 0, n_launch = 0, first_t = 0, last_t = 0;

  always @(negedge clk) begin
    if (rst) begin
      chk({ser_o, bit_clk_o, launch_o, trig_clk_o, trig_stb_o} == 5'b0,
          "R1 outputs in reset", {ser_o, bit_clk_o, launch_o, trig_clk_o, trig_stb_o}, 0);
      blf = 7'h01; exp_ser = 1'b0;
    end else begin
      chk(trig_clk_o == m_tclk, "R2 clean clock", trig_clk_o, m_tclk);
      chk(trig_stb_o == m_tstb, "R2 R9 clean strobe", trig_stb_o, m_tstb);
      if (coinc) begin
        chk(launch_o == trig_stb_o, "R5 launch vs strobe", launch_o, trig_stb_o);
        chk(bit_clk_o == trig_clk_o, "R5 bit clock vs clean", bit_clk_o, trig_clk_o);
      end
      if (launch_o) begin
        exp_ser = blf[6];
        blf = {blf[5:0], blf[6] ^ blf[5]};
      end
      chk(ser_o == exp_ser, "R4 serial bit", ser_o, exp_ser);
      if (trig_stb_o) last_trig = cyc;
      if (launch_o) begin
        if (r9_en && r9_prev >= 0)
          chk(cyc - r9_prev >= 32 && cyc - r9_prev <= 64, "R9 no runt bit", cyc - r9_prev, 32);
        if (meas) begin
          int d;
          if (m_prev >= 0)
            chk(cyc - m_prev >= 50 && cyc - m_prev <= 78, "R7 launch interval", cyc - m_prev, 64);
          else first_t = cyc;
          d = (((cyc - last_trig) % 64) + 64) % 64;
          if (d >= 32) d -= 64;
          if (d < 0) d = -d;
          if (d > max_err) max_err = d;
          n_launch++;
          last_t = cyc;
        end
        r9_prev = r9_en ? cyc : -1;
        m_prev  = meas ? cyc : -1;
      end
      if (!r9_en) r9_prev = -1;
      if (!meas)  m_prev  = -1;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired before completion");
      finish_run();
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    // R5: zero amplitude, data edges on clean edges
    coinc = 1;
    wait_cyc(3000);
    // R9: step change in the middle of a bit
    r9_en = 1;
    wait_cyc(17);
    ftw = 32'h0800_0000;
    wait_cyc(2000);
    ftw = 32'h0400_0000;
    wait_cyc(2000);
    r9_en = 0;
    // R6 R7 R8: sinusoidal jitter
    coinc = 0;
    amp = 8'd200;
    wait_cyc(5000);
    meas = 1;
    wait_cyc(40960);
    meas = 0;
    wait_cyc(1);
    chk(max_err >= 9 && max_err <= 14, "R6 peak timing error", max_err, 12);
    chk(n_launch > 600, "R8 launch count", n_launch, 640);
    begin
      int span_err;
      span_err = (last_t - first_t) - 64 * (n_launch - 1);
      if (span_err < 0) span_err = -span_err;
      chk(span_err <= 26, "R8 average period", last_t - first_t, 64 * (n_launch - 1));
    end
    // Back to zero amplitude: R5 again
    amp = 8'd0;
    wait_cyc(4000);
    coinc = 1;
    wait_cyc(2000);
    coinc = 0;
    // R1: reset in mid-run restores seed and clears outputs
    rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    coinc = 1;
    wait_cyc(1500);
    done = 1;
    finish_run();
  end

endmodule